// File: doc/BRIEF.md
# Vector Find-First-Mismatch Unit

The unit takes two 128-bit operand vectors, A and B, cuts them into equal lanes of 8, 16 or 32 bits, and looks for the lowest-numbered lane in which A and B disagree. When zero search is turned on, it also looks for the lowest-numbered lane of A whose value is zero. The earlier of the two positions is reported as a byte offset. A condition code says what was found. When a mismatch decides the result, the code also says whether A's lane is smaller or larger than B's lane, with both read as unsigned numbers.

The unit fits in an execution pipeline. Each operand set is presented with a single-cycle strobe. Its result appears on the registered outputs one clock later and stays there until the next strobe. Instruction decode and register-file access are not part of the unit. The caller supplies the lane size and the zero-search enable as decoded inputs.

Top module: `vfm_top`

## Requirements
- R1: `out_valid` is high exactly one clock after each cycle in which `in_valid` is high and low otherwise. `result` and `cc` change only on the clock edge that follows an `in_valid` cycle, and hold their values in between.
- R2: `lane_sz` selects the lane width: 0 gives 1 byte, 1 gives 2 bytes, 2 gives 4 bytes, and 3 behaves exactly like 2. Byte offset 0 is bits 127:120. Lane k starts at byte offset k × lane width, and its most significant byte is the one at the lowest offset.
- R3: With `zero_en` low, the index is the byte offset of the lowest-numbered lane whose A and B values differ. If all lanes are equal, the index is 16.
- R4: With `zero_en` high, the index is the smaller of two values: the mismatch offset, and the byte offset of the lowest-numbered all-zero lane of A. Each of these is 16 when there is none.
- R5: `result[127:64]` holds the index, zero-extended. `result[63:0]` is always zero.
- R6: `cc` is 3 when there is no mismatch and no counted zero lane.
- R7: `cc` is 0 when a counted zero lane lies strictly before the first mismatch, including the case where there is no mismatch at all. `cc` is never 0 when `zero_en` is low.
- R8: In the remaining cases, `cc` is 1 when A's lane at the first mismatch is smaller than B's lane as unsigned numbers, and 2 when it is larger.
- R9: When the first zero lane of A and the first mismatch share a byte offset, `cc` is 1 or 2 according to R8, never 0.
- R10: While `rst_n` is low, `out_valid`, `result` and `cc` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe, one cycle per operation |
| lane_sz | input | 2 | Lane width code (0: 8, 1: 16, 2/3: 32 bits) |
| zero_en | input | 1 | Enables the zero-lane search on A |
| vec_a | input | 128 | Operand A |
| vec_b | input | 128 | Operand B |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 128 | Index in the upper doubleword, zero in the lower |
| cc | output | 2 | Condition code (0 to 3) |

## Verification
All three results (`out_valid`, `result` and `cc`) are due on the first rising edge after the strobe cycle, because there is one register stage. The bench drives operands on a falling edge and reads the outputs on the next falling edge, which lies half a period after the capturing edge. After that it drops the strobe and changes the operands. One idle cycle later it checks that the outputs have held. The sweep covers every lane-size code, both zero-search settings, every mismatch lane, every zero lane (including "none" and the shared-lane case) and both orderings of the mismatched pair. Expected values are derived from the chosen lane numbers, not by scanning the vectors.

// File: rtl/vfm_pkg.sv
package vfm_pkg;

    typedef enum logic [1:0] {
        LANE_B8    = 2'd0,
        LANE_B16   = 2'd1,
        LANE_B32   = 2'd2,
        LANE_B32_X = 2'd3
    } lane_sz_e;

    typedef enum logic [1:0] {
        CC_ZERO_FIRST = 2'd0,
        CC_A_SMALLER  = 2'd1,
        CC_A_LARGER   = 2'd2,
        CC_NOTHING    = 2'd3
    } vfm_cc_e;

    localparam int unsigned NUM_LANE_SIZES = 3;

endpackage

// File: rtl/vfm_lane_scan.sv
module vfm_lane_scan #(
    parameter int unsigned VBYTES = 16,
    parameter int unsigned EBYTES = 1,
    localparam int unsigned VW    = VBYTES * 8,
    localparam int unsigned IDXW  = $clog2(VBYTES + 1)
) (
    input  logic [VW-1:0]   op_a,
    input  logic [VW-1:0]   op_b,
    output logic [IDXW-1:0] diff_off,
    output logic [IDXW-1:0] zero_off,
    output logic            a_below
);
    localparam int unsigned EW    = EBYTES * 8;
    localparam int unsigned NLANE = VBYTES / EBYTES;

    // Walk from the last lane down to lane 0, so the lowest lane wins.
    always_comb begin
        diff_off = IDXW'(VBYTES);
        zero_off = IDXW'(VBYTES);
        a_below  = 1'b0;
        for (int i = NLANE - 1; i >= 0; i--) begin
            logic [EW-1:0] la;
            logic [EW-1:0] lb;
            la = op_a[VW-1-i*EW -: EW];
            lb = op_b[VW-1-i*EW -: EW];
            if (la != lb) begin
                diff_off = IDXW'(i * EBYTES);
                a_below  = (la < lb);
            end
            if (la == '0) begin
                zero_off = IDXW'(i * EBYTES);
            end
        end
    end

endmodule

// File: rtl/vfm_cc_gen.sv
module vfm_cc_gen
    import vfm_pkg::*;
#(
    parameter int unsigned VBYTES = 16,
    localparam int unsigned IDXW  = $clog2(VBYTES + 1)
) (
    input  logic [IDXW-1:0] diff_off,
    input  logic [IDXW-1:0] zero_off,
    input  logic            a_below,
    input  logic            zero_en,
    output logic [IDXW-1:0] first_off,
    output vfm_cc_e         cc_code
);
    localparam logic [IDXW-1:0] NONE = IDXW'(VBYTES);

    logic [IDXW-1:0] zero_eff;

    always_comb begin
        zero_eff  = zero_en ? zero_off : NONE;
        first_off = (zero_eff < diff_off) ? zero_eff : diff_off;
        if ((zero_eff == NONE) && (diff_off == NONE)) begin
            cc_code = CC_NOTHING;
        end else if (zero_eff < diff_off) begin
            cc_code = CC_ZERO_FIRST;
        end else if (a_below) begin
            cc_code = CC_A_SMALLER;
        end else begin
            cc_code = CC_A_LARGER;
        end
    end

endmodule

// File: rtl/vfm_top.sv
module vfm_top
    import vfm_pkg::*;
#(
    parameter int unsigned VBYTES = 16,
    localparam int unsigned VW    = VBYTES * 8,
    localparam int unsigned HW    = VW / 2,
    localparam int unsigned IDXW  = $clog2(VBYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [1:0]    lane_sz,
    input  logic          zero_en,
    input  logic [VW-1:0] vec_a,
    input  logic [VW-1:0] vec_b,
    output logic          out_valid,
    output logic [VW-1:0] result,
    output logic [1:0]    cc
);

    typedef struct packed {
        logic            vld;
        logic [IDXW-1:0] off;
        logic [1:0]      code;
    } vfm_state_t;

    logic [IDXW-1:0] diff_arr [NUM_LANE_SIZES];
    logic [IDXW-1:0] zero_arr [NUM_LANE_SIZES];
    logic            below_arr[NUM_LANE_SIZES];

    // One scanner per lane width.
    for (genvar g = 0; g < NUM_LANE_SIZES; g++) begin : g_scan
        vfm_lane_scan #(
            .VBYTES (VBYTES),
            .EBYTES (1 << g)
        ) u_scan (
            .op_a     (vec_a),
            .op_b     (vec_b),
            .diff_off (diff_arr[g]),
            .zero_off (zero_arr[g]),
            .a_below  (below_arr[g])
        );
    end

    logic [IDXW-1:0] diff_sel;
    logic [IDXW-1:0] zero_sel;
    logic            below_sel;
    logic [IDXW-1:0] first_off;
    vfm_cc_e         cc_code;

    always_comb begin
        case (lane_sz_e'(lane_sz))
            LANE_B8: begin
                diff_sel  = diff_arr[0];
                zero_sel  = zero_arr[0];
                below_sel = below_arr[0];
            end
            LANE_B16: begin
                diff_sel  = diff_arr[1];
                zero_sel  = zero_arr[1];
                below_sel = below_arr[1];
            end
            default: begin
                diff_sel  = diff_arr[2];
                zero_sel  = zero_arr[2];
                below_sel = below_arr[2];
            end
        endcase
    end

    vfm_cc_gen #(
        .VBYTES (VBYTES)
    ) u_cc (
        .diff_off  (diff_sel),
        .zero_off  (zero_sel),
        .a_below   (below_sel),
        .zero_en   (zero_en),
        .first_off (first_off),
        .cc_code   (cc_code)
    );

    vfm_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.off  = first_off;
            st_d.code = cc_code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign result    = {{(HW - IDXW){1'b0}}, st_q.off, {HW{1'b0}}};
    assign cc        = st_q.code;

    // R1: strobe follows input by one cycle; outputs hold while idle
    p_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(cc)));
    // R3: index never exceeds the not-found value
    p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (result[VW-1:HW] <= VBYTES));
    // R5: lower doubleword is always zero
    p_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (result[HW-1:0] == '0));
    // R6: code 3 only with the not-found index
    p_nothing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cc == 2'd3) |-> (result[VW-1:HW] == VBYTES));
    // R7: code 0 requires zero search
    p_zero_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !zero_en) |=> (cc != 2'd0));

endmodule

// File: tb/tb_vfm_top.sv
module tb_vfm_top;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [1:0]   lane_sz;
    logic         zero_en;
    logic [127:0] vec_a;
    logic [127:0] vec_b;
    logic         out_valid;
    logic [127:0] result;
    logic [1:0]   cc;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    vfm_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .lane_sz   (lane_sz),
        .zero_en   (zero_en),
        .vec_a     (vec_a),
        .vec_b     (vec_b),
        .out_valid (out_valid),
        .result    (result),
        .cc        (cc)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] set_byte(input logic [127:0] v, input int pos, input logic [7:0] val);
        logic [127:0] r;
        r = v;
        r[127-pos*8 -: 8] = val;
        return r;
    endfunction

    // m, z: lane numbers (nl means none); rel=1 makes A larger at the mismatch
    task automatic run_case(input int code, input bit zen, input int m, input int z, input bit rel);
        int sz, nl, mis, zo, idx, ecc;
        bit smaller;
        logic [127:0] a, b;
        sz = (code == 0) ? 1 : (code == 1) ? 2 : 4;
        nl = 16 / sz;
        for (int j = 0; j < 16; j++) begin
            a = (j == 0) ? '0 : a;
            a = set_byte(a, j, 8'h21 + 8'(j));
        end
        b = a;
        if (z < nl) begin
            for (int j = 0; j < sz; j++) begin
                a = set_byte(a, z*sz + j, 8'h00);
                if (z != m) b = set_byte(b, z*sz + j, 8'h00);
            end
        end
        if (m < nl) begin
            if (m == z) begin
                b = set_byte(b, m*sz, 8'h5A);
            end else begin
                a = set_byte(a, m*sz, rel ? 8'hF0 : 8'h0F);
                b = set_byte(b, m*sz, rel ? 8'h0F : 8'hF0);
            end
        end
        mis = (m < nl) ? m*sz : 16;
        zo  = (zen && z < nl) ? z*sz : 16;
        idx = (zo < mis) ? zo : mis;
        smaller = (m == z) ? 1'b1 : !rel;
        if (mis == 16 && zo == 16)  ecc = 3;
        else if (zo < mis)          ecc = 0;
        else                        ecc = smaller ? 1 : 2;

        @(negedge clk);
        in_valid = 1'b1; lane_sz = 2'(code); zero_en = zen; vec_a = a; vec_b = b;
        @(negedge clk);
        check("R1 valid", 128'(out_valid), 128'd1);
        if (zen) check("R4 index", result, {64'(idx), 64'd0});
        else     check("R3 index", result, {64'(idx), 64'd0});
        check("R5 low half", 128'(result[63:0]), 128'd0);
        if (ecc == 3)      check("R6 cc", 128'(cc), 128'(ecc));
        else if (ecc == 0) check("R7 cc", 128'(cc), 128'(ecc));
        else if (m == z && zen) check("R9 cc", 128'(cc), 128'(ecc));
        else               check("R8 cc", 128'(cc), 128'(ecc));
        if (code == 3) check("R2 alias idx", result, {64'(idx), 64'd0});
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; lane_sz = 2'd0; zero_en = 1'b0;
        vec_a = '0; vec_b = '1;
        repeat (3) @(negedge clk);
        check("R10 valid", 128'(out_valid), 128'd0);
        check("R10 result", result, 128'd0);
        check("R10 cc", 128'(cc), 128'd0);
        rst_n = 1'b1;

        for (int code = 0; code < 4; code++)
            for (int zen = 0; zen < 2; zen++)
                for (int m = 0; m <= 16; m++)
                    for (int z = 0; z <= 16; z++)
                        for (int rel = 0; rel < 2; rel++) begin
                            int nl;
                            nl = (code == 0) ? 16 : (code == 1) ? 8 : 4;
                            if (m <= nl && z <= nl)
                                run_case(code, zen[0], m, z, rel[0]);
                        end

        // R1: hold while idle, even with changed operands
        run_case(0, 1'b0, 3, 16, 1'b1);
        in_valid = 1'b0; vec_a = '0; vec_b = '1; zero_en = 1'b1;
        @(negedge clk);
        check("R1 idle valid", 128'(out_valid), 128'd0);
        check("R1 hold result", result, {64'd3, 64'd0});
        check("R1 hold cc", 128'(cc), 128'd2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule